// File: doc/BRIEF.md
# Interrupt Line Enable, Pending and Active Register Bank

This block holds the per-line state for 32 peripheral interrupt lines and exposes it on a simple 32-bit word-addressed read/write bus. Every line has an enable bit, a pending bit, an active bit and a 3-bit priority level. Software sets and clears enable and pending bits through separate write-one-to-set and write-one-to-clear words, so it never needs a read-modify-write sequence. Priorities are kept four lines to a word, one byte per line.

Rising edges on the peripheral request inputs latch into the pending bits. The processor core drives two pulses with a line index. The acknowledge pulse moves a line from pending to active. The completion pulse retires the active line. A line stays active while another line is acknowledged on top of it. The enable, pending, active and priority state is also presented as parallel outputs for an external arbiter, which is not part of this block.

Top module: `irq_line_bank`

## Requirements
- R1: After reset, every enable, pending, active and priority bit is zero. All bus reads return zero.
- R2: A bus write to word 0 sets the enable bits where the data has a 1. A write to word 1 clears the enable bits where the data has a 1. Data bits that are 0 have no effect. Reads of word 0 and of word 1 both return the enable bits, with bit n for line n.
- R3: A bus write to word 2 sets the pending bits where the data has a 1, with no hardware request needed. A write to word 3 clears the pending bits where the data has a 1. Data bits that are 0 have no effect. Reads of word 2 and of word 3 both return the pending bits.
- R4: A 0-to-1 change on request input n, seen at a clock edge, sets pending bit n at that edge. A request held high does not set the bit again after software clears it.
- R5: An acknowledge pulse for line n clears pending bit n and sets active bit n at the same clock edge. If a software set or a new request edge for line n arrives in that same cycle, pending bit n stays set.
- R6: An active bit clears only on a completion pulse for its own line. It stays set while other lines are acknowledged and completed.
- R7: A request edge on a line that is active sets its pending bit again. After completion, the line is left pending and idle, so it is serviced once more.
- R8: The priority of line n is held in byte n mod 4 of word 8 + n/4. Only the top 3 bits of each byte are stored, and the low 5 bits read as zero, so writing 0xFF reads back 0xE0.
- R9: Word 4 returns the active bits and is read-only. Writes to it change nothing, and active bits rise only on an acknowledge pulse.
- R10: The outputs lineEnable, linePending and lineActive carry the bits of line n at bit n. linePrio carries the level of line n at bits 3n+2 down to 3n.
- R11: Reads of words 5, 6 and 7 return zero. Writes to those words change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busSel | input | 1 | Bus access in this cycle |
| busWrite | input | 1 | 1 = write, 0 = read |
| busAddr | input | 4 | Word address |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, valid in the cycle of the access |
| irqLines | input | 32 | Peripheral request inputs, one per line |
| ackValid | input | 1 | Acknowledge pulse from the core |
| ackLine | input | 5 | Line being acknowledged |
| doneValid | input | 1 | Completion pulse from the core |
| doneLine | input | 5 | Line being completed |
| lineEnable | output | 32 | Enable bit per line |
| linePending | output | 32 | Pending bit per line |
| lineActive | output | 32 | Active bit per line |
| linePrio | output | 96 | 3-bit priority level per line |

## Verification
The assertions check on every cycle the rules that are local to one edge:
- an acknowledge makes its line active and clears its pending bit unless a set arrives with it;
- active bits fall only on completion and rise only on acknowledge;
- enable bits rise only where a set-word write carried a 1;
- pending bits rise only from a software set or a request edge;
- priority reads never show the low bits.

The bench scenarios cover what takes a sequence of events:
- preemption, where two lines are active and retire in nested order;
- re-pending of an active line and its second service;
- a request held high after software clears it;
- the mapping of every line's priority byte and output slice, swept over all eight levels.

// File: rtl/irq_bank_pkg.sv
package irq_bank_pkg;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int unsigned LINE_COUNT     = 32;
  localparam int unsigned DATA_W         = 32;
  localparam int unsigned ADDR_W         = 4;
  localparam int unsigned PRIO_BITS      = 3;
  localparam int unsigned BYTE_W         = 8;
  localparam int unsigned LINES_PER_WORD = DATA_W / BYTE_W;
  localparam int unsigned IDX_W          = $clog2(LINE_COUNT);
  localparam int unsigned PRIO_WORDS     = LINE_COUNT / LINES_PER_WORD;
  localparam int unsigned PW_W           = $clog2(PRIO_WORDS);
  localparam int unsigned LOW_BITS       = BYTE_W - PRIO_BITS;

  // word offsets; the priority window base fixes the line-to-byte mapping
  localparam int unsigned OFS_EN_SET  = 0;
  localparam int unsigned OFS_EN_CLR  = 1;
  localparam int unsigned OFS_PD_SET  = 2;
  localparam int unsigned OFS_PD_CLR  = 3;
  localparam int unsigned OFS_ACTIVE  = 4;
  localparam int unsigned PRIO_BASE   = 8;

  typedef enum logic [2:0] {
    RD_NONE,
    RD_ENABLE,
    RD_PENDING,
    RD_ACTIVE,
    RD_PRIO
  } rdKind_e;

  typedef struct packed {
    logic            enSet;
    logic            enClr;
    logic            pdSet;
    logic            pdClr;
    logic            prioWr;
    logic [PW_W-1:0] prioWord;
    rdKind_e         rdKind;
    logic            ackStb;
    logic [IDX_W-1:0] ackIdx;
    logic            doneStb;
    logic [IDX_W-1:0] doneIdx;
  } bankStrobes_t;
endpackage

// File: rtl/irq_bank_ctrl.sv
module irq_bank_ctrl
  import irq_bank_pkg::*;
(
  input  logic              busSel,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              ackValid,
  input  logic [IDX_W-1:0]  ackLine,
  input  logic              doneValid,
  input  logic [IDX_W-1:0]  doneLine,
  output bankStrobes_t      stb
);
  timeunit 1ns;
  timeprecision 1ps;

  logic wrHit;
  logic rdHit;
  logic inPrio;

  assign wrHit  = busSel && busWrite;
  assign rdHit  = busSel && !busWrite;
  assign inPrio = (busAddr >= ADDR_W'(PRIO_BASE)) &&
                  ({1'b0, busAddr} < (ADDR_W + 1)'(PRIO_BASE + PRIO_WORDS));

  always_comb begin
    stb          = '0;
    stb.rdKind   = RD_NONE;
    stb.prioWord = PW_W'(busAddr - ADDR_W'(PRIO_BASE));
    stb.ackStb   = ackValid;
    stb.ackIdx   = ackLine;
    stb.doneStb  = doneValid;
    stb.doneIdx  = doneLine;
    if (inPrio) begin
      stb.prioWr = wrHit;
      if (rdHit) stb.rdKind = RD_PRIO;
    end else begin
      case (busAddr)
        ADDR_W'(OFS_EN_SET): begin
          stb.enSet = wrHit;
          if (rdHit) stb.rdKind = RD_ENABLE;
        end
        ADDR_W'(OFS_EN_CLR): begin
          stb.enClr = wrHit;
          if (rdHit) stb.rdKind = RD_ENABLE;
        end
        ADDR_W'(OFS_PD_SET): begin
          stb.pdSet = wrHit;
          if (rdHit) stb.rdKind = RD_PENDING;
        end
        ADDR_W'(OFS_PD_CLR): begin
          stb.pdClr = wrHit;
          if (rdHit) stb.rdKind = RD_PENDING;
        end
        ADDR_W'(OFS_ACTIVE): begin
          if (rdHit) stb.rdKind = RD_ACTIVE;
        end
        default: stb.rdKind = RD_NONE;
      endcase
    end
  end
endmodule

// File: rtl/irq_bank_datapath.sv
module irq_bank_datapath
  import irq_bank_pkg::*;
(
  input  logic                            clk,
  input  logic                            rstN,
  input  bankStrobes_t                    stb,
  input  logic [DATA_W-1:0]               busWdata,
  input  logic [LINE_COUNT-1:0]           irqLines,
  output logic [LINE_COUNT-1:0]           enable,
  output logic [LINE_COUNT-1:0]           pending,
  output logic [LINE_COUNT-1:0]           active,
  output logic [LINE_COUNT*PRIO_BITS-1:0] prioFlat,
  output logic [DATA_W-1:0]               rdData
);
  timeunit 1ns;
  timeprecision 1ps;

  logic [LINE_COUNT-1:0] irqPrev;
  logic [LINE_COUNT-1:0] irqRise;
  logic [LINE_COUNT-1:0] wrBits;
  logic [LINE_COUNT-1:0] ackMask;
  logic [LINE_COUNT-1:0] doneMask;
  logic [LINE_COUNT-1:0] enableNext;
  logic [LINE_COUNT-1:0] pendingNext;
  logic [LINE_COUNT-1:0] activeNext;
  logic [DATA_W-1:0]     prioWordData;

  assign wrBits   = busWdata[LINE_COUNT-1:0];
  assign irqRise  = irqLines & ~irqPrev;
  assign ackMask  = stb.ackStb  ? (LINE_COUNT'(1) << stb.ackIdx)  : '0;
  assign doneMask = stb.doneStb ? (LINE_COUNT'(1) << stb.doneIdx) : '0;

  always_comb begin
    enableNext = enable;
    if (stb.enSet) enableNext = enable | wrBits;
    if (stb.enClr) enableNext = enable & ~wrBits;
  end

  // clears first, then sets: a fresh request survives an acknowledge
  always_comb begin
    pendingNext = pending & ~ackMask;
    if (stb.pdClr) pendingNext = pendingNext & ~wrBits;
    pendingNext = pendingNext | irqRise;
    if (stb.pdSet) pendingNext = pendingNext | wrBits;
  end

  assign activeNext = (active & ~doneMask) | ackMask;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enable  <= '0;
      pending <= '0;
      active  <= '0;
      irqPrev <= '0;
    end else begin
      enable  <= enableNext;
      pending <= pendingNext;
      active  <= activeNext;
      irqPrev <= irqLines;
    end
  end

  for (genvar g = 0; g < LINE_COUNT; g++) begin : gPrio
    localparam int unsigned WORD_IDX = g / LINES_PER_WORD;
    localparam int unsigned TOP_BIT  = (g % LINES_PER_WORD) * BYTE_W + BYTE_W - 1;
    logic [PRIO_BITS-1:0] level;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) level <= '0;
      else if (stb.prioWr && (stb.prioWord == PW_W'(WORD_IDX)))
        level <= busWdata[TOP_BIT -: PRIO_BITS];
    end
    assign prioFlat[g*PRIO_BITS +: PRIO_BITS] = level;
  end

  always_comb begin
    prioWordData = '0;
    for (int b = 0; b < LINES_PER_WORD; b++) begin
      prioWordData[b*BYTE_W +: BYTE_W] =
        {prioFlat[(int'(stb.prioWord) * LINES_PER_WORD + b) * PRIO_BITS +: PRIO_BITS],
         {LOW_BITS{1'b0}}};
    end
  end

  always_comb begin
    case (stb.rdKind)
      RD_ENABLE:  rdData = DATA_W'(enable);
      RD_PENDING: rdData = DATA_W'(pending);
      RD_ACTIVE:  rdData = DATA_W'(active);
      RD_PRIO:    rdData = prioWordData;
      default:    rdData = '0;
    endcase
  end
endmodule

// File: rtl/irq_line_bank.sv
module irq_line_bank
  import irq_bank_pkg::*;
(
  input  logic                            clk,
  input  logic                            rstN,
  input  logic                            busSel,
  input  logic                            busWrite,
  input  logic [ADDR_W-1:0]               busAddr,
  input  logic [DATA_W-1:0]               busWdata,
  output logic [DATA_W-1:0]               busRdata,
  input  logic [LINE_COUNT-1:0]           irqLines,
  input  logic                            ackValid,
  input  logic [IDX_W-1:0]                ackLine,
  input  logic                            doneValid,
  input  logic [IDX_W-1:0]                doneLine,
  output logic [LINE_COUNT-1:0]           lineEnable,
  output logic [LINE_COUNT-1:0]           linePending,
  output logic [LINE_COUNT-1:0]           lineActive,
  output logic [LINE_COUNT*PRIO_BITS-1:0] linePrio
);
  timeunit 1ns;
  timeprecision 1ps;

  bankStrobes_t stb;

  irq_bank_ctrl i_ctrl (
    .busSel    (busSel),
    .busWrite  (busWrite),
    .busAddr   (busAddr),
    .ackValid  (ackValid),
    .ackLine   (ackLine),
    .doneValid (doneValid),
    .doneLine  (doneLine),
    .stb       (stb)
  );

  irq_bank_datapath i_datapath (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .busWdata (busWdata),
    .irqLines (irqLines),
    .enable   (lineEnable),
    .pending  (linePending),
    .active   (lineActive),
    .prioFlat (linePrio),
    .rdData   (busRdata)
  );
endmodule

// File: rtl/irq_line_bank_chk.sv
module irq_line_bank_chk
  import irq_bank_pkg::*;
(
  input logic                  clk,
  input logic                  rstN,
  input logic                  busSel,
  input logic                  busWrite,
  input logic [ADDR_W-1:0]     busAddr,
  input logic [DATA_W-1:0]     busWdata,
  input logic [DATA_W-1:0]     busRdata,
  input logic [LINE_COUNT-1:0] irqLines,
  input logic                  ackValid,
  input logic [IDX_W-1:0]      ackLine,
  input logic                  doneValid,
  input logic [IDX_W-1:0]      doneLine,
  input logic [LINE_COUNT-1:0] lineEnable,
  input logic [LINE_COUNT-1:0] linePending,
  input logic [LINE_COUNT-1:0] lineActive
);
  timeunit 1ns;
  timeprecision 1ps;

  localparam logic [DATA_W-1:0] LOW_MASK =
    {LINES_PER_WORD{BYTE_W'((1 << LOW_BITS) - 1)}};

  logic [LINE_COUNT-1:0] seenIrq;
  logic [LINE_COUNT-1:0] riseNow;
  logic [LINE_COUNT-1:0] enSetBits;
  logic [LINE_COUNT-1:0] pdSetBits;
  logic [LINE_COUNT-1:0] reAssert;
  logic [LINE_COUNT-1:0] doneBits;
  logic                  prioRead;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) seenIrq <= '0;
    else       seenIrq <= irqLines;
  end

  assign riseNow   = irqLines & ~seenIrq;
  assign enSetBits = (busSel && busWrite && busAddr == ADDR_W'(OFS_EN_SET)) ? busWdata[LINE_COUNT-1:0] : '0;
  assign pdSetBits = (busSel && busWrite && busAddr == ADDR_W'(OFS_PD_SET)) ? busWdata[LINE_COUNT-1:0] : '0;
  assign reAssert  = riseNow | pdSetBits;
  assign doneBits  = doneValid ? (LINE_COUNT'(1) << doneLine) : '0;
  assign prioRead  = busSel && !busWrite && (busAddr >= ADDR_W'(PRIO_BASE));

  AST_ACK_MAKES_ACTIVE: assert property (@(posedge clk) disable iff (!rstN)
    ackValid |=> lineActive[$past(ackLine)]); // R5

  AST_ACK_DROPS_PENDING: assert property (@(posedge clk) disable iff (!rstN)
    (ackValid && !reAssert[ackLine]) |=> !linePending[$past(ackLine)]); // R5

  AST_DONE_RETIRES: assert property (@(posedge clk) disable iff (!rstN)
    (doneValid && !(ackValid && ackLine == doneLine)) |=> !lineActive[$past(doneLine)]); // R6

  AST_ACTIVE_FALLS_ON_DONE: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (($past(lineActive) & ~lineActive & ~$past(doneBits)) == '0)); // R6

  AST_ACTIVE_RISES_ON_ACK: assert property (@(posedge clk) disable iff (!rstN)
    !ackValid |=> ((lineActive & ~$past(lineActive)) == '0)); // R9

  AST_ENABLE_RISES_ON_SET: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((lineEnable & ~$past(lineEnable) & ~$past(enSetBits)) == '0)); // R2

  AST_PENDING_HAS_SOURCE: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((linePending & ~$past(linePending) & ~$past(reAssert)) == '0)); // R4

  AST_PRIO_LOW_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    prioRead |-> ((busRdata & LOW_MASK) == '0)); // R8
endmodule

bind irq_line_bank irq_line_bank_chk u_irq_line_bank_chk (.*);

// File: tb/test_irq_line_bank.sv
module test_irq_line_bank;
  timeunit 1ns;
  timeprecision 1ps;
  import irq_bank_pkg::*;

  logic                            clk = 1'b0;
  logic                            rstN = 1'b0;
  logic                            busSel = 1'b0;
  logic                            busWrite = 1'b0;
  logic [ADDR_W-1:0]               busAddr = '0;
  logic [DATA_W-1:0]               busWdata = '0;
  logic [DATA_W-1:0]               busRdata;
  logic [LINE_COUNT-1:0]           irqLines = '0;
  logic                            ackValid = 1'b0;
  logic [IDX_W-1:0]                ackLine = '0;
  logic                            doneValid = 1'b0;
  logic [IDX_W-1:0]                doneLine = '0;
  logic [LINE_COUNT-1:0]           lineEnable;
  logic [LINE_COUNT-1:0]           linePending;
  logic [LINE_COUNT-1:0]           lineActive;
  logic [LINE_COUNT*PRIO_BITS-1:0] linePrio;

  always #2 clk = ~clk;

  irq_line_bank i_irq_line_bank (.*);

  int errCnt = 0;
  int chkCnt = 0;
  bit summaryDone = 1'b0;
  logic [31:0] expEn = '0, expPd = '0, expAct = '0;
  logic [2:0]  expPrio [32];

  task automatic expectEq(input string tag, input logic [95:0] act, input logic [95:0] exp);
    chkCnt++;
    if (act !== exp) begin
      errCnt++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic busWr(input int a, input logic [31:0] d);
    @(negedge clk);
    busSel = 1'b1; busWrite = 1'b1; busAddr = ADDR_W'(a); busWdata = d;
    @(negedge clk);
    busSel = 1'b0; busWrite = 1'b0; busWdata = '0;
  endtask

  task automatic busRd(input int a, output logic [31:0] d);
    @(negedge clk);
    busSel = 1'b1; busWrite = 1'b0; busAddr = ADDR_W'(a);
    #1 d = busRdata;
    busSel = 1'b0;
  endtask

  task automatic pulseAck(input int l);
    @(negedge clk); ackValid = 1'b1; ackLine = IDX_W'(l);
    @(negedge clk); ackValid = 1'b0;
  endtask

  task automatic pulseDone(input int l);
    @(negedge clk); doneValid = 1'b1; doneLine = IDX_W'(l);
    @(negedge clk); doneValid = 1'b0;
  endtask

  function automatic logic [95:0] prioVector();
    logic [95:0] v = '0;
    for (int n = 0; n < 32; n++) v[n*3 +: 3] = expPrio[n];
    return v;
  endfunction

  task automatic chkOutputs(input string tag);
    #1;
    expectEq({tag, " R10 enable"},  96'(lineEnable),  96'(expEn));
    expectEq({tag, " R10 pending"}, 96'(linePending), 96'(expPd));
    expectEq({tag, " R10 active"},  96'(lineActive),  96'(expAct));
  endtask

  task automatic chkRead(input string tag, input int a, input logic [31:0] exp);
    logic [31:0] d;
    busRd(a, d);
    expectEq(tag, 96'(d), 96'(exp));
  endtask

  initial begin
    #400000;
    if (!summaryDone) begin
      errCnt++; chkCnt++;
      $display("FAIL watchdog expired actual=running expected=finished");
      summaryDone = 1'b1;
      $display("Result: errors=%0d of %0d checks", errCnt, chkCnt);
      $finish;
    end
  end

  initial begin
    logic [31:0] w;
    for (int n = 0; n < 32; n++) expPrio[n] = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    chkOutputs("R1 reset");
    expectEq("R1 reset prio", linePrio, 96'(0));
    for (int a = 0; a < 16; a++) chkRead("R1 reset read", a, '0);

    // R2 enable set/clear per line, reads at both words
    for (int i = 0; i < 32; i++) begin
      busWr(OFS_EN_SET, 32'h1 << i); expEn |= 32'h1 << i;
      chkRead("R2 enable set read", OFS_EN_SET, expEn);
    end
    busWr(OFS_EN_SET, '0);
    busWr(OFS_EN_CLR, '0);
    chkRead("R2 zero writes no effect", OFS_EN_CLR, expEn);
    busWr(OFS_EN_CLR, 32'h5555_5555); expEn &= ~32'h5555_5555;
    chkRead("R2 enable clear read", OFS_EN_CLR, expEn);
    chkOutputs("R2 enable");

    // R8 priority sweep: every line at every level, low bits junk
    for (int wd = 0; wd < 8; wd++) begin
      for (int v = 0; v < 8; v++) begin
        logic [31:0] d = '0, e = '0;
        for (int b = 0; b < 4; b++) begin
          logic [2:0] lv = 3'((v + b) % 8);
          d[b*8 +: 8] = {lv, 5'((v * 3 + b * 7) % 32)};
          e[b*8 +: 8] = {lv, 5'b0};
          expPrio[wd*4 + b] = lv;
        end
        busWr(PRIO_BASE + wd, d);
        chkRead("R8 priority readback", PRIO_BASE + wd, e);
      end
      expectEq("R10 priority vector", linePrio, prioVector());
    end
    busWr(PRIO_BASE, 32'hFFFF_FFFF);
    for (int b = 0; b < 4; b++) expPrio[b] = 3'h7;
    chkRead("R8 all ones reads E0", PRIO_BASE, 32'hE0E0_E0E0);
    #1 expectEq("R10 priority after ones", linePrio, prioVector());

    // R3 software pending
    busWr(OFS_PD_SET, 32'hA5A5_0F0F); expPd = 32'hA5A5_0F0F;
    chkRead("R3 pending set read", OFS_PD_SET, expPd);
    busWr(OFS_PD_SET, '0);
    busWr(OFS_PD_CLR, '0);
    chkRead("R3 zero writes no effect", OFS_PD_CLR, expPd);
    busWr(OFS_PD_CLR, 32'h0000_FFFF); expPd &= ~32'h0000_FFFF;
    chkRead("R3 pending clear read", OFS_PD_CLR, expPd);
    busWr(OFS_PD_CLR, 32'hFFFF_FFFF); expPd = '0;
    chkOutputs("R3 cleared");

    // R4 edge sweep
    for (int i = 0; i < 32; i++) begin
      @(negedge clk); irqLines[i] = 1'b1;
      @(negedge clk); irqLines[i] = 1'b0; expPd |= 32'h1 << i;
      #1 expectEq("R4 edge sets pending", 96'(linePending), 96'(expPd));
    end
    busWr(OFS_PD_CLR, 32'hFFFF_FFFF); expPd = '0;
    @(negedge clk); irqLines[3] = 1'b1;
    @(negedge clk); expPd[3] = 1'b1;
    #1 expectEq("R4 held line pends once", 96'(linePending), 96'(expPd));
    busWr(OFS_PD_CLR, 32'h8); expPd[3] = 1'b0;
    repeat (3) @(negedge clk);
    #1 expectEq("R4 held level no repend", 96'(linePending), 96'(expPd));
    irqLines[3] = 1'b0;

    // R5 acknowledge
    busWr(OFS_PD_SET, 32'h1 << 5); expPd[5] = 1'b1;
    pulseAck(5); expPd[5] = 1'b0; expAct[5] = 1'b1;
    chkOutputs("R5 ack line 5");
    chkRead("R9 active read", OFS_ACTIVE, expAct);

    // R6 preemption by line 9, nested retire
    busWr(OFS_PD_SET, 32'h1 << 9); expPd[9] = 1'b1;
    pulseAck(9); expPd[9] = 1'b0; expAct[9] = 1'b1;
    chkOutputs("R6 two active");
    pulseDone(9); expAct[9] = 1'b0;
    chkOutputs("R6 outer stays active");
    pulseDone(5); expAct[5] = 1'b0;
    chkOutputs("R6 all retired");

    // R7 request while active
    busWr(OFS_PD_SET, 32'h1 << 7); expPd[7] = 1'b1;
    pulseAck(7); expPd[7] = 1'b0; expAct[7] = 1'b1;
    @(negedge clk); irqLines[7] = 1'b1;
    @(negedge clk); irqLines[7] = 1'b0; expPd[7] = 1'b1;
    chkOutputs("R7 repend while active");
    pulseDone(7); expAct[7] = 1'b0;
    chkOutputs("R7 pending after done");
    pulseAck(7); expPd[7] = 1'b0; expAct[7] = 1'b1;
    chkOutputs("R7 second service");
    pulseDone(7); expAct[7] = 1'b0;

    // R5 ack with same-cycle edge keeps pending
    busWr(OFS_PD_SET, 32'h1 << 12); expPd[12] = 1'b1;
    @(negedge clk); ackValid = 1'b1; ackLine = IDX_W'(12); irqLines[12] = 1'b1;
    @(negedge clk); ackValid = 1'b0; irqLines[12] = 1'b0; expAct[12] = 1'b1;
    chkOutputs("R5 ack with new edge");

    // R9 active word read-only
    busWr(OFS_ACTIVE, 32'hFFFF_FFFF);
    chkRead("R9 write to active ignored", OFS_ACTIVE, expAct);
    pulseDone(12); expAct[12] = 1'b0;

    // R11 unmapped words
    for (int a = 5; a < 8; a++) begin
      busWr(a, 32'hFFFF_FFFF);
      chkRead("R11 unmapped read zero", a, '0);
    end
    chkOutputs("R11 state unchanged");
    expectEq("R11 prio unchanged", linePrio, prioVector());

    summaryDone = 1'b1;
    $display("Result: errors=%0d of %0d checks", errCnt, chkCnt);
    $finish;
  end
endmodule